// File: doc/BRIEF.md
# Network controller bring-up sequencer

This block brings a serially attached Ethernet controller from power-up to a working UDP socket without any software help. After reset it walks a fixed program of register writes. The first group goes to the controller's common register block and the second to the socket-0 register block. The last write opens the socket. The block then keeps reading the socket status register until the controller reports that the socket is ready for UDP. At that point it raises `ready`. Every address, mask, port and hardware address it writes comes from a module parameter.

The block does not drive the serial bus itself. It sends one transaction at a time to a frame master, and each transaction carries one byte. The request fields are held steady until the frame master returns a one-cycle done pulse. A register wider than one byte is sent as consecutive single-byte writes at rising addresses. A synchronous restart input throws away all progress and runs the program again from the start.

The state machine has five states:
- BOOT lasts one idle cycle after reset or restart. Transition *boot_go* leads to WRITE.
- WRITE steps through the program one byte per done pulse. Transition *prog_end* leads to POLL_RD after the open command.
- POLL_RD reads the socket status register. Transition *sock_up* leads to READY when the status is 0x22. Transition *sock_down* leads to POLL_WAIT for any other status.
- POLL_WAIT idles for the configured gap. Transition *gap_over* leads back to POLL_RD.
- READY holds the ready flag high.

Transition *restart* leads from any state to BOOT.

Top module: `netctl_bringup`

## Requirements
- R1: While reset is held, and in the one BOOT cycle after it, `ready` and `cmd_valid` are low. The first write request appears in the cycle after BOOT.
- R2: The common-block writes use block select 0x00 and come in this order: mode 0x00 at 0x0000, gateway at 0x0001 (4 bytes), subnet mask at 0x0005 (4 bytes), local MAC at 0x0009 (6 bytes), local IP at 0x000F (4 bytes), interrupt flags 0xFF at 0x0015, interrupt mask 0xFF at 0x0016, retry time 0x07D0 at 0x0019 (2 bytes), retry count 0x08 at 0x001B, and PHY setting 0xFF at 0x002E.
- R3: A value wider than one byte is sent as one single-byte write per byte. The most significant byte goes first, to the register's base address, and each following byte goes to the next address.
- R4: After the common block, the socket writes use block select 0x01 and come in this order: socket mode 0x02 at 0x0000, local port at 0x0004 (2 bytes), peer MAC at 0x0006 (6 bytes), peer IP at 0x000C (4 bytes), peer port at 0x0010 (2 bytes), socket interrupt flags 0xFF at 0x0002, and segment size 0x05B4 at 0x0012 (2 bytes).
- R5: The last write of the program is the open command, 0x01 to socket address 0x0001.
- R6: A request is held with unchanged fields and `cmd_valid` high until `cmd_done` pulses. A write request has `cmd_write` high. The block moves to the next item only on that pulse.
- R7: Right after the open command is accepted, the block issues a read request with `cmd_write` low, block select 0x01 and address 0x0003. There is no idle cycle in between, and `cmd_wdata` is 0 during the read.
- R8: If a completed status read returns anything other than 0x22, `cmd_valid` stays low for exactly POLL_GAP cycles. The same read is then issued again.
- R9: `ready` rises in the cycle after a status read completes with 0x22, and never earlier. While `ready` is high, `cmd_valid` stays low, and `ready` stays high until a restart.
- R10: A restart pulse moves the block to BOOT at the next edge from any state, including READY and POLL_WAIT. The whole program then runs again from its first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous request to rerun the whole program |
| cmd_valid | output | 1 | A single-byte transaction is requested |
| cmd_write | output | 1 | 1 = write transaction, 0 = read transaction |
| cmd_blk | output | 5 | Register block select (0x00 common, 0x01 socket 0) |
| cmd_addr | output | 16 | Register address inside the block |
| cmd_wdata | output | 8 | Byte to write (0 during reads) |
| cmd_done | input | 1 | One-cycle pulse: the requested transaction has finished |
| cmd_rdata | input | 8 | Byte read, valid in the cycle of `cmd_done` |
| ready | output | 1 | The socket reported the UDP-ready status |

## Verification
Two events can land in the same cycle here: a restart pulse can arrive while the poll gap timer is still counting, and the end of a status read leads straight into that timer. The bench makes a status read return a non-ready value. It waits until the block is idling in the gap, then pulses restart before the gap runs out. It then checks three things: requests drop at once, no stray poll read appears, and the full program replays byte for byte ahead of the next status read. A second collision is the final open command with the first status read. The bench checks that the read follows the write with no idle cycle in between.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
    localparam int ADDR_W  = 16;
    localparam int BLK_W   = 5;
    localparam int BYTE_W  = 8;
    localparam int VAL_W   = 48;
    localparam int LEN_W   = 3;
    localparam int N_STEPS = 18;
    localparam int STEP_W  = $clog2(N_STEPS);

    localparam logic [BLK_W-1:0]  BLK_COMMON  = 5'h00;
    localparam logic [BLK_W-1:0]  BLK_SOCK0   = 5'h01;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 16'h0003;
    localparam logic [BYTE_W-1:0] UDP_UP_CODE = 8'h22;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BLK_W-1:0]  blk;
        logic [LEN_W-1:0]  len;
        logic [VAL_W-1:0]  val;
    } wr_step_t;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_WRITE,
        ST_POLL_RD,
        ST_POLL_WAIT,
        ST_READY
    } seq_state_t;
endpackage

// File: rtl/netctl_step_rom.sv
module netctl_step_rom
    import netctl_pkg::*;
#(
    parameter logic [31:0] GW_IP      = 32'hC0A8_0101,
    parameter logic [31:0] NET_MASK   = 32'hFFFF_FF00,
    parameter logic [47:0] LOCAL_MAC  = 48'h0200_0000_0001,
    parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0164,
    parameter logic [15:0] LOCAL_PORT = 16'h1F90,
    parameter logic [47:0] PEER_MAC   = 48'hFFFF_FFFF_FFFF,
    parameter logic [31:0] PEER_IP    = 32'hC0A8_0102,
    parameter logic [15:0] PEER_PORT  = 16'h1770
) (
    input  logic [STEP_W-1:0] idx,
    output wr_step_t          step
);
    function automatic wr_step_t mk(input logic [ADDR_W-1:0] a, input logic [BLK_W-1:0] b,
                                    input logic [LEN_W-1:0] l, input logic [VAL_W-1:0] v);
        wr_step_t s;
        s.addr = a;
        s.blk  = b;
        s.len  = l;
        s.val  = v;
        return s;
    endfunction

    // Program order is behaviour: common block first, socket block next, open last.
    always_comb begin
        case (int'(idx))
            0:  step = mk(16'h0000, BLK_COMMON, 3'd1, 48'h00);
            1:  step = mk(16'h0001, BLK_COMMON, 3'd4, {16'h0, GW_IP});
            2:  step = mk(16'h0005, BLK_COMMON, 3'd4, {16'h0, NET_MASK});
            3:  step = mk(16'h0009, BLK_COMMON, 3'd6, LOCAL_MAC);
            4:  step = mk(16'h000F, BLK_COMMON, 3'd4, {16'h0, LOCAL_IP});
            5:  step = mk(16'h0015, BLK_COMMON, 3'd1, 48'hFF);
            6:  step = mk(16'h0016, BLK_COMMON, 3'd1, 48'hFF);
            7:  step = mk(16'h0019, BLK_COMMON, 3'd2, 48'h07D0);
            8:  step = mk(16'h001B, BLK_COMMON, 3'd1, 48'h08);
            9:  step = mk(16'h002E, BLK_COMMON, 3'd1, 48'hFF);
            10: step = mk(16'h0000, BLK_SOCK0,  3'd1, 48'h02);
            11: step = mk(16'h0004, BLK_SOCK0,  3'd2, {32'h0, LOCAL_PORT});
            12: step = mk(16'h0006, BLK_SOCK0,  3'd6, PEER_MAC);
            13: step = mk(16'h000C, BLK_SOCK0,  3'd4, {16'h0, PEER_IP});
            14: step = mk(16'h0010, BLK_SOCK0,  3'd2, {32'h0, PEER_PORT});
            15: step = mk(16'h0002, BLK_SOCK0,  3'd1, 48'hFF);
            16: step = mk(16'h0012, BLK_SOCK0,  3'd2, 48'h05B4);
            17: step = mk(16'h0001, BLK_SOCK0,  3'd1, 48'h01);
            default: step = mk(16'h0000, BLK_COMMON, 3'd1, 48'h00);
        endcase
    end
endmodule

// File: rtl/netctl_byte_pick.sv
module netctl_byte_pick
    import netctl_pkg::*;
(
    input  logic [VAL_W-1:0]  val,
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  idx,
    output logic [BYTE_W-1:0] byte_out
);
    logic [LEN_W-1:0] pos;
    logic [VAL_W-1:0] shifted;

    // Byte 0 of the transfer is the most significant byte of the value.
    always_comb begin
        pos      = len - idx - LEN_W'(1);
        shifted  = val >> {pos, 3'b000};
        byte_out = shifted[BYTE_W-1:0];
    end
endmodule

// File: rtl/netctl_poll_timer.sv
module netctl_poll_timer #(
    parameter int GAP = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(GAP + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (!run) cnt <= '0;
        else          cnt <= cnt + CNT_W'(1);
    end

    assign expired = run && (cnt == CNT_W'(GAP - 1));

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < CNT_W'(GAP))) else $error("gap counter overran"); // R8
endmodule

// File: rtl/netctl_bringup.sv
module netctl_bringup
    import netctl_pkg::*;
#(
    parameter logic [31:0] GW_IP      = 32'hC0A8_0101,
    parameter logic [31:0] NET_MASK   = 32'hFFFF_FF00,
    parameter logic [47:0] LOCAL_MAC  = 48'h0200_0000_0001,
    parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0164,
    parameter logic [15:0] LOCAL_PORT = 16'h1F90,
    parameter logic [47:0] PEER_MAC   = 48'hFFFF_FFFF_FFFF,
    parameter logic [31:0] PEER_IP    = 32'hC0A8_0102,
    parameter logic [15:0] PEER_PORT  = 16'h1770,
    parameter int          POLL_GAP   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [BLK_W-1:0]  cmd_blk,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BYTE_W-1:0] cmd_wdata,
    input  logic              cmd_done,
    input  logic [BYTE_W-1:0] cmd_rdata,
    output logic              ready
);
    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [LEN_W-1:0]  byte_q, byte_d;
    wr_step_t          cur;
    logic [BYTE_W-1:0] cur_byte;
    logic              gap_over;

    netctl_step_rom #(
        .GW_IP(GW_IP), .NET_MASK(NET_MASK), .LOCAL_MAC(LOCAL_MAC), .LOCAL_IP(LOCAL_IP),
        .LOCAL_PORT(LOCAL_PORT), .PEER_MAC(PEER_MAC), .PEER_IP(PEER_IP), .PEER_PORT(PEER_PORT)
    ) u_rom (
        .idx  (step_q),
        .step (cur)
    );

    netctl_byte_pick u_pick (
        .val      (cur.val),
        .len      (cur.len),
        .idx      (byte_q),
        .byte_out (cur_byte)
    );

    netctl_poll_timer #(.GAP(POLL_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_POLL_WAIT),
        .expired (gap_over)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            step_q  <= '0;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            byte_q  <= byte_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        byte_d  = byte_q;
        if (restart) begin
            state_d = ST_BOOT;
            step_d  = '0;
            byte_d  = '0;
        end else begin
            unique case (state_q)
                ST_BOOT: begin
                    state_d = ST_WRITE;
                    step_d  = '0;
                    byte_d  = '0;
                end
                ST_WRITE: begin
                    if (cmd_done) begin
                        if (byte_q == cur.len - LEN_W'(1)) begin
                            byte_d = '0;
                            if (step_q == STEP_W'(N_STEPS - 1)) state_d = ST_POLL_RD;
                            else                                step_d  = step_q + STEP_W'(1);
                        end else begin
                            byte_d = byte_q + LEN_W'(1);
                        end
                    end
                end
                ST_POLL_RD: begin
                    if (cmd_done)
                        state_d = (cmd_rdata == UDP_UP_CODE) ? ST_READY : ST_POLL_WAIT;
                end
                ST_POLL_WAIT: begin
                    if (gap_over) state_d = ST_POLL_RD;
                end
                ST_READY: state_d = ST_READY;
                default:  state_d = ST_BOOT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
        cmd_blk   = BLK_COMMON;
        cmd_addr  = '0;
        cmd_wdata = '0;
        ready     = 1'b0;
        unique case (state_q)
            ST_WRITE: begin
                cmd_valid = 1'b1;
                cmd_write = 1'b1;
                cmd_blk   = cur.blk;
                cmd_addr  = cur.addr + ADDR_W'(byte_q);
                cmd_wdata = cur_byte;
            end
            ST_POLL_RD: begin
                cmd_valid = 1'b1;
                cmd_blk   = BLK_SOCK0;
                cmd_addr  = STATUS_ADDR;
            end
            ST_READY: ready = 1'b1;
            ST_BOOT, ST_POLL_WAIT: ;
            default: ;
        endcase
    end

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done && !restart) |=>
            (cmd_valid && $stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_write) && $stable(cmd_blk)))
        else $error("request changed before done"); // R6
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !cmd_valid) else $error("request while ready"); // R9
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !restart) |=> ready) else $error("ready dropped"); // R9
    AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(cmd_done) && !$past(cmd_write) && $past(cmd_rdata) == UDP_UP_CODE))
        else $error("ready without ready status"); // R9
    AST_RESTART_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!cmd_valid && !ready)) else $error("restart not honoured"); // R10
endmodule

// File: tb/netctl_bringup_tb.sv
module netctl_bringup_tb;
    localparam int          GAP   = 5;
    localparam logic [31:0] GW    = 32'hC0A8_0101;
    localparam logic [31:0] MASK  = 32'hFFFF_FF00;
    localparam logic [47:0] LMAC  = 48'h0008_DC11_2233;
    localparam logic [31:0] LIP   = 32'hC0A8_0164;
    localparam logic [15:0] LPORT = 16'h1F90;
    localparam logic [47:0] PMAC  = 48'hA1B2_C3D4_E5F6;
    localparam logic [31:0] PIP   = 32'hC0A8_0102;
    localparam logic [15:0] PPORT = 16'h1770;

    typedef struct packed {
        logic        w;
        logic [4:0]  blk;
        logic [15:0] addr;
        logic [7:0]  data;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0;
    logic cmd_valid, cmd_write, ready;
    logic [4:0] cmd_blk;
    logic [15:0] cmd_addr;
    logic [7:0] cmd_wdata;
    logic cmd_done = 1'b0;
    logic [7:0] cmd_rdata = 8'h00;

    int checks = 0, failures = 0, n_txn = 0;
    int lowcnt = 0, last_low = 0;
    bit prev_v = 0, prev_rd = 0, wait_seen = 0, finished = 0;

    item_t exp_q[$];
    string tag_q[$];
    logic [7:0] stat_q[$];

    logic [15:0] t_addr[18];
    logic [4:0]  t_blk[18];
    int          t_len[18];
    logic [47:0] t_val[18];
    string       t_tag[18];

    always #4 clk = ~clk;

    netctl_bringup #(
        .GW_IP(GW), .NET_MASK(MASK), .LOCAL_MAC(LMAC), .LOCAL_IP(LIP), .LOCAL_PORT(LPORT),
        .PEER_MAC(PMAC), .PEER_IP(PIP), .PEER_PORT(PPORT), .POLL_GAP(GAP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_blk(cmd_blk), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .ready(ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic set_step(input int i, input logic [15:0] a, input logic [4:0] b,
                            input int l, input logic [47:0] v, input string tg);
        t_addr[i] = a; t_blk[i] = b; t_len[i] = l; t_val[i] = v;
        t_tag[i] = (l > 1) ? {"R3/", tg} : tg;
    endtask

    task automatic init_table();
        set_step(0,  16'h0000, 5'h00, 1, 48'h00, "R2");
        set_step(1,  16'h0001, 5'h00, 4, {16'h0, GW}, "R2");
        set_step(2,  16'h0005, 5'h00, 4, {16'h0, MASK}, "R2");
        set_step(3,  16'h0009, 5'h00, 6, LMAC, "R2");
        set_step(4,  16'h000F, 5'h00, 4, {16'h0, LIP}, "R2");
        set_step(5,  16'h0015, 5'h00, 1, 48'hFF, "R2");
        set_step(6,  16'h0016, 5'h00, 1, 48'hFF, "R2");
        set_step(7,  16'h0019, 5'h00, 2, 48'h07D0, "R2");
        set_step(8,  16'h001B, 5'h00, 1, 48'h08, "R2");
        set_step(9,  16'h002E, 5'h00, 1, 48'hFF, "R2");
        set_step(10, 16'h0000, 5'h01, 1, 48'h02, "R4");
        set_step(11, 16'h0004, 5'h01, 2, {32'h0, LPORT}, "R4");
        set_step(12, 16'h0006, 5'h01, 6, PMAC, "R4");
        set_step(13, 16'h000C, 5'h01, 4, {16'h0, PIP}, "R4");
        set_step(14, 16'h0010, 5'h01, 2, {32'h0, PPORT}, "R4");
        set_step(15, 16'h0002, 5'h01, 1, 48'hFF, "R4");
        set_step(16, 16'h0012, 5'h01, 2, 48'h05B4, "R4");
        set_step(17, 16'h0001, 5'h01, 1, 48'h01, "R5");
    endtask

    // Driver: push the expected transactions of one program run plus n_reads polls
    task automatic push_run(input int n_reads);
        item_t it;
        for (int i = 0; i < 18; i++) begin
            for (int b = 0; b < t_len[i]; b++) begin
                logic [47:0] sh;
                sh      = t_val[i] >> (8 * (t_len[i] - 1 - b));
                it.w    = 1'b1;
                it.blk  = t_blk[i];
                it.addr = t_addr[i] + 16'(b);
                it.data = sh[7:0];
                exp_q.push_back(it);
                tag_q.push_back(t_tag[i]);
            end
        end
        for (int r = 0; r < n_reads; r++) begin
            it = '{w: 1'b0, blk: 5'h01, addr: 16'h0003, data: 8'h00};
            exp_q.push_back(it);
            tag_q.push_back("R7");
        end
    endtask

    // Idle-run tracker for request gaps
    always @(negedge clk) begin
        if (!cmd_valid) lowcnt++;
        else begin
            last_low = prev_v ? 0 : lowcnt;
            lowcnt   = 0;
        end
        prev_v = cmd_valid;
    end

    // Frame-master model and scoreboard monitor
    initial begin
        item_t cap, e;
        string tg;
        logic [7:0] st;
        int lat;
        wait (rst_n);
        forever begin
            @(negedge clk); #1;
            if (rst_n && cmd_valid) begin
                cap = '{w: cmd_write, blk: cmd_blk, addr: cmd_addr, data: cmd_wdata};
                if (!cap.w) begin
                    if (prev_rd) check(last_low == GAP, "R8", "idle cycles before repoll", last_low, GAP);
                    else         check(last_low == 0, "R7", "idle cycles before first poll", last_low, 0);
                    check(ready == 1'b0, "R9", "ready during poll", ready, 0);
                end
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected transaction", cap, 0);
                end else begin
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(cap == e, tg, "transaction {w,blk,addr,data}", cap, e);
                end
                lat = n_txn % 3;
                n_txn++;
                repeat (lat) @(negedge clk);
                check(cmd_valid && cap == {cmd_write, cmd_blk, cmd_addr, cmd_wdata},
                      "R6", "request held until done", {cmd_valid, cmd_write, cmd_blk, cmd_addr, cmd_wdata},
                      {1'b1, cap});
                st = 8'h00;
                if (!cap.w) begin
                    st = (stat_q.size() > 0) ? stat_q.pop_front() : 8'h22;
                    cmd_rdata = st;
                end
                cmd_done = 1'b1;
                @(negedge clk);
                cmd_done  = 1'b0;
                cmd_rdata = 8'h00;
                #1;
                if (!cap.w && st == 8'h22) begin
                    check(ready == 1'b1, "R9", "ready after 0x22", ready, 1);
                    check(cmd_valid == 1'b0, "R9", "no request when ready", cmd_valid, 0);
                end else if (!cap.w) begin
                    check(cmd_valid == 1'b0 && ready == 1'b0, "R8", "idle after non-ready status",
                          {cmd_valid, ready}, 0);
                    wait_seen = 1;
                end
                prev_rd = !cap.w && st != 8'h22;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (60000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        init_table();
        push_run(3);
        stat_q.push_back(8'h00);
        stat_q.push_back(8'h13);
        stat_q.push_back(8'h22);
        repeat (3) @(negedge clk);
        #1;
        check(ready == 1'b0 && cmd_valid == 1'b0, "R1", "outputs in reset", {ready, cmd_valid}, 0);
        rst_n = 1'b1;
        #1;
        check(cmd_valid == 1'b0, "R1", "boot cycle quiet", cmd_valid, 0);

        wait (ready);
        repeat (4) @(negedge clk);
        #1;
        check(ready == 1'b1 && cmd_valid == 1'b0, "R9", "ready held", {ready, cmd_valid}, 2'b10);

        // Restart from READY
        push_run(1);
        stat_q.push_back(8'h22);
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        #1;
        check(ready == 1'b0 && cmd_valid == 1'b0, "R10", "restart from ready", {ready, cmd_valid}, 0);
        wait (ready);
        repeat (2) @(negedge clk);

        // Restart while the poll gap is counting
        push_run(1);
        stat_q.push_back(8'h05);
        wait_seen = 0;
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        wait (wait_seen);
        push_run(1);
        stat_q.push_back(8'h22);
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        #1;
        check(ready == 1'b0 && cmd_valid == 1'b0, "R10", "restart during gap", {ready, cmd_valid}, 0);
        wait (ready);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10", "all expected transactions seen", exp_q.size(), 0);
        check(stat_q.size() == 0, "R8", "all status replies consumed", stat_q.size(), 0);
        finish_up();
    end
endmodule